// File: doc/BRIEF.md
# Power-Good Reset Sequencer with Mode Strap

This block produces the processor reset, the shared bus reset, a legacy-bus reset and an internal reset, all derived from a board power-good level. A static strap input picks who owns the bus reset. The block samples the strap on every bus clock while power is bad and freezes it when power-good is seen high. With the strap high, the block drives the active-low bus reset itself. With the strap low, the block releases the bus reset and treats the pin as an input from an external reset agent.

After power-good rises, the processor reset is stretched by a programmable number of bus clocks in both modes. In the driving mode, the bus reset and the internal resets are stretched by the same count. In the input mode, the bus reset pin is sampled on the bus clock once power is good. Its active-low level, inverted, asserts the processor reset, the internal reset and the legacy-bus reset. An external pulse shorter than the minimum width still resets the chip, and it also sets a sticky violation flag. Only a power loss clears that flag.

Top module: `pwrgood_reset_seq`

## Requirements
- R1: While `pwr_good_i` is low, `cpu_rst_o`, `int_rst_o` and `legacy_rst_o` are 1 and `ext_short_o` is 0.
- R2: A strap of 1 sampled while power is bad gives `busrst_oe_o`=1 and `busrst_n_o`=0 one clock later.
- R3: A strap of 0 sampled while power is bad gives `busrst_oe_o`=0 one clock later.
- R4: The mode frozen at the power-good rise is kept, and strap changes have no effect until power-good falls again.
- R5: `pwr_good_i` passes through a 2-stage synchronizer. `cpu_rst_o` stays 1 for exactly `HOLD_CLKS` clocks after the synchronized rise, so a rise driven before clock c releases it after edge c+2+HOLD_CLKS.
- R6: In driving mode, `busrst_n_o`, `int_rst_o` and `legacy_rst_o` follow the same stretch as `cpu_rst_o`, and `busrst_n_i` is ignored.
- R7: In input mode with power good, `busrst_n_i`=0 sampled at a clock edge makes `cpu_rst_o`, `int_rst_o` and `legacy_rst_o` 1 after that edge. They return to 0 one clock after the pin is seen high again, once the stretch is over.
- R8: In input mode, `int_rst_o` and `legacy_rst_o` are released when the synchronized power-good goes high, and they do not wait for the stretch.
- R9: An input-mode pulse seen for fewer than `MIN_EXT_CLKS` clocks sets `ext_short_o` one clock after the pulse ends. A pulse of `MIN_EXT_CLKS` or more clocks does not set it. The flag stays set until power-good falls.
- R10: A fall of `pwr_good_i` asserts the processor and internal resets without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| pwr_good_i | input | 1 | Board power-good level, asynchronous |
| strap_i | input | 1 | Mode strap: 1 drives the bus reset, 0 accepts it |
| busrst_n_i | input | 1 | Bus reset pin level, active low |
| busrst_n_o | output | 1 | Bus reset drive value, active low |
| busrst_oe_o | output | 1 | Bus reset output enable |
| cpu_rst_o | output | 1 | Processor reset, active high |
| legacy_rst_o | output | 1 | Legacy-bus reset, active high |
| int_rst_o | output | 1 | Internal logic reset, active high |
| ext_short_o | output | 1 | Sticky flag for a too-short external reset |

## Verification
A power-good rise reaches the logic two clocks after it is driven, and the stretch then releases the processor reset `HOLD_CLKS` clocks later. A change on the bus reset pin shows on the outputs one clock after it is driven. The violation flag rises two clocks after the pin returns high. A strap value appears on the output enable one clock after it is driven, and a power-good fall acts immediately. The driver turns each of these latencies into an absolute cycle number for every expected item. The monitor compares on the falling clock edge of exactly that cycle, and it flags any item whose cycle has already passed.

// File: rtl/pgrs_pkg.sv
package pgrs_pkg;
  // Who owns the bus reset line after power-up.
  typedef enum logic {
    AGENT_SELF = 1'b0,
    AGENT_EXT  = 1'b1
  } agent_e;
endpackage

// File: rtl/pgrs_sync.sv
module pgrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic async_ni,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  // Asserts at once, releases after STAGES edges.
  always_ff @(posedge clk_i or negedge async_ni) begin
    if (!async_ni) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgrs_hold_timer.sv
module pgrs_hold_timer #(
  parameter int HOLD_CLKS = 33000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign cnt_en = !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pgrs_ext_mon.sv
module pgrs_ext_mon #(
  parameter int MIN_EXT_CLKS = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bus_rst_ni,
  output logic active_o,
  output logic short_o
);
  localparam int WW = $clog2(MIN_EXT_CLKS + 1);
  localparam logic [WW-1:0] WMAX = WW'(MIN_EXT_CLKS);

  logic          smp_q, smp_d;
  logic [WW-1:0] wid_q, wid_d;
  logic          short_q, short_d;
  logic          pulse_end;

  // Pin sampled once per clock, only meaningful when the pin is an input.
  assign smp_d     = en_i & ~bus_rst_ni;
  assign pulse_end = !smp_q && (wid_q != '0);

  always_comb begin
    wid_d   = wid_q;
    short_d = short_q;
    if (smp_q) begin
      if (wid_q != WMAX) wid_d = wid_q + 1'b1;
    end else begin
      wid_d = '0;
    end
    if (pulse_end && (wid_q < WMAX)) short_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q   <= 1'b0;
      wid_q   <= '0;
      short_q <= 1'b0;
    end else begin
      smp_q   <= smp_d;
      wid_q   <= wid_d;
      short_q <= short_d;
    end
  end

  assign active_o = smp_q;
  assign short_o  = short_q;
endmodule

// File: rtl/pwrgood_reset_seq.sv
module pwrgood_reset_seq
  import pgrs_pkg::*;
#(
  parameter int HOLD_CLKS    = 33000,
  parameter int MIN_EXT_CLKS = 80,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic pwr_good_i,
  input  logic strap_i,
  input  logic busrst_n_i,
  output logic busrst_n_o,
  output logic busrst_oe_o,
  output logic cpu_rst_o,
  output logic legacy_rst_o,
  output logic int_rst_o,
  output logic ext_short_o
);
  logic   pg_q;
  agent_e agent_q, agent_d;
  logic   agent_en;
  logic   hold_done;
  logic   ext_mode;
  logic   ext_active;
  logic   ext_rst;
  logic   hold_act;
  logic   grp_rst;

  pgrs_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
    .clk_i    (clk_i),
    .async_ni (pwr_good_i),
    .sync_o   (pg_q)
  );

  // Strap register: tracks the pin while power is bad, frozen once it is good.
  // It has no reset on purpose: power-good low is exactly when it must sample.
  assign agent_en = !pg_q;
  assign agent_d  = strap_i ? AGENT_SELF : AGENT_EXT;

  always_ff @(posedge clk_i) begin
    if (agent_en) agent_q <= agent_d;
  end

  assign ext_mode = (agent_q == AGENT_EXT);

  pgrs_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (pg_q),
    .done_o (hold_done)
  );

  pgrs_ext_mon #(.MIN_EXT_CLKS(MIN_EXT_CLKS)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (pg_q),
    .en_i       (ext_mode),
    .bus_rst_ni (busrst_n_i),
    .active_o   (ext_active),
    .short_o    (ext_short_o)
  );

  assign hold_act = !hold_done;
  assign ext_rst  = ext_mode & ext_active;

  // Reset group for internal and legacy logic, by mode.
  always_comb begin
    if (ext_mode) grp_rst = !pg_q | ext_rst;
    else          grp_rst = hold_act;
  end

  assign cpu_rst_o    = hold_act | ext_rst;
  assign busrst_oe_o  = !ext_mode;
  assign busrst_n_o   = !hold_act;
  assign int_rst_o    = grp_rst;
  assign legacy_rst_o = grp_rst;
endmodule

// File: rtl/pgrs_checker.sv
module pgrs_checker #(
  parameter int HOLD_CLKS = 33000
) (
  input logic clk_i,
  input logic pwr_good_i,
  input logic pg_q_i,
  input logic busrst_n_i,
  input logic busrst_n_o,
  input logic busrst_oe_o,
  input logic cpu_rst_o,
  input logic legacy_rst_o,
  input logic int_rst_o,
  input logic ext_short_o
);
  logic [31:0] up_q;

  // Cycles since synchronized power-good, saturating.
  always_ff @(posedge clk_i or negedge pg_q_i) begin
    if (!pg_q_i)                 up_q <= '0;
    else if (up_q != 32'hFFFFFFFF) up_q <= up_q + 32'd1;
  end

  p_pg_low_rst_r1: assert property (@(posedge clk_i)
    !pwr_good_i |-> (cpu_rst_o && int_rst_o && legacy_rst_o && !ext_short_o));

  p_mode_frozen_r4: assert property (@(posedge clk_i) disable iff (!pg_q_i)
    $past(pg_q_i) |-> $stable(busrst_oe_o));

  p_hold_len_r5: assert property (@(posedge clk_i) disable iff (!pg_q_i)
    !cpu_rst_o |-> (up_q >= 32'(HOLD_CLKS)));

  p_self_bus_r6: assert property (@(posedge clk_i) disable iff (!pg_q_i)
    busrst_oe_o |-> ((busrst_n_o == !cpu_rst_o) && (int_rst_o == cpu_rst_o)));

  p_ext_follow_r7: assert property (@(posedge clk_i) disable iff (!pg_q_i)
    (!busrst_oe_o && $past(pg_q_i) && !$past(busrst_n_i))
      |-> (cpu_rst_o && int_rst_o && legacy_rst_o));

  p_short_sticky_r9: assert property (@(posedge clk_i) disable iff (!pg_q_i)
    ext_short_o |=> ext_short_o);
endmodule

bind pwrgood_reset_seq pgrs_checker #(.HOLD_CLKS(HOLD_CLKS)) u_pgrs_checker (
  .clk_i        (clk_i),
  .pwr_good_i   (pwr_good_i),
  .pg_q_i       (pg_q),
  .busrst_n_i   (busrst_n_i),
  .busrst_n_o   (busrst_n_o),
  .busrst_oe_o  (busrst_oe_o),
  .cpu_rst_o    (cpu_rst_o),
  .legacy_rst_o (legacy_rst_o),
  .int_rst_o    (int_rst_o),
  .ext_short_o  (ext_short_o)
);

// File: tb/pwrgood_reset_seq_bench.sv
module pwrgood_reset_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 120;
  localparam int MINW       = 80;

  // Vector order: {cpu, int, legacy, oe, bus_n, short}
  localparam logic [5:0] M_ALL  = 6'b111111;
  localparam logic [5:0] M_NOBN = 6'b111101;

  typedef struct {
    int         cyc;
    string      req;
    logic [5:0] val;
    logic [5:0] msk;
  } exp_t;

  logic clk;
  logic pwr_good_i, strap_i, busrst_n_i;
  logic busrst_n_o, busrst_oe_o, cpu_rst_o, legacy_rst_o, int_rst_o, ext_short_o;

  int   cyc;
  int   n_chk;
  int   n_fail;
  exp_t sb_q[$];

  pwrgood_reset_seq #(.HOLD_CLKS(HOLD), .MIN_EXT_CLKS(MINW), .SYNC_STAGES(2)) u_pwrgood_reset_seq (
    .clk_i        (clk),
    .pwr_good_i   (pwr_good_i),
    .strap_i      (strap_i),
    .busrst_n_i   (busrst_n_i),
    .busrst_n_o   (busrst_n_o),
    .busrst_oe_o  (busrst_oe_o),
    .cpu_rst_o    (cpu_rst_o),
    .legacy_rst_o (legacy_rst_o),
    .int_rst_o    (int_rst_o),
    .ext_short_o  (ext_short_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] outs();
    return {cpu_rst_o, int_rst_o, legacy_rst_o, busrst_oe_o, busrst_n_o, ext_short_o};
  endfunction

  task automatic check(string req, logic [5:0] exp_v, logic [5:0] msk);
    logic [5:0] act;
    act = outs();
    n_chk++;
    if ((act & msk) !== (exp_v & msk)) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)", req, cyc, act, exp_v, msk);
    end
  endtask

  task automatic push(int c, string req, logic [5:0] v, logic [5:0] m);
    exp_t e;
    e.cyc = c; e.req = req; e.val = v; e.msk = m;
    sb_q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic step_to(int c);
    while (cyc < c) step(1);
  endtask

  // Monitor: compares each expected item in its own cycle.
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      e = sb_q.pop_front();
      if (e.cyc < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s: item for cycle %0d missed, actual cycle %0d expected %0d", e.req, e.cyc, cyc, e.cyc);
      end else begin
        check(e.req, e.val, e.msk);
      end
    end
  end

  bit done;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    finish_run();
  end

  initial begin
    int c0, c1, c2, c3, c4, c5;
    n_chk = 0; n_fail = 0; done = 1'b0;
    pwr_good_i = 1'b0; strap_i = 1'b1; busrst_n_i = 1'b1;

    // R1 R2: reset state with the strap high while power is bad
    step(4);
    push(cyc + 1, "R1 R2", 6'b111100, M_ALL);

    // Driving mode power-up
    step(2);
    c0 = cyc;
    pwr_good_i = 1'b1;
    push(c0 + 1, "R5", 6'b111100, M_ALL);
    push(c0 + 2 + HOLD - 1, "R6", 6'b111100, M_ALL);
    push(c0 + 2 + HOLD, "R5", 6'b000110, M_ALL);
    step(10);
    strap_i = 1'b0;      // R4: must be ignored
    busrst_n_i = 1'b0;   // R6: must be ignored
    push(c0 + HOLD + 10, "R4 R6", 6'b000110, M_ALL);
    step_to(c0 + HOLD + 12);
    busrst_n_i = 1'b1;

    // R10: asynchronous power loss, strap now low
    pwr_good_i = 1'b0;
    #1;
    check("R10", 6'b111000, 6'b111001);
    c1 = cyc;
    push(c1 + 1, "R3", 6'b111000, M_NOBN);

    // Input mode power-up
    step(3);
    c2 = cyc;
    pwr_good_i = 1'b1;
    push(c2 + 2, "R8", 6'b100000, M_NOBN);
    step(3);
    strap_i = 1'b1;      // R4: must be ignored
    push(c2 + 2 + HOLD - 1, "R5", 6'b100000, M_NOBN);
    push(c2 + 2 + HOLD, "R5 R4", 6'b000000, M_NOBN);
    step_to(c2 + HOLD + 6);

    // R7: legal pulse of exactly the minimum width
    c3 = cyc;
    busrst_n_i = 1'b0;
    push(c3 + 1, "R7", 6'b111000, M_NOBN);
    push(c3 + MINW, "R7", 6'b111000, M_NOBN);
    step(MINW);
    busrst_n_i = 1'b1;
    push(c3 + MINW + 1, "R7", 6'b000000, M_NOBN);
    push(c3 + MINW + 2, "R9", 6'b000000, M_NOBN);

    // R9: one clock short, still passed through, flag sticks
    step(5);
    c4 = cyc;
    busrst_n_i = 1'b0;
    push(c4 + 1, "R9", 6'b111000, M_NOBN);
    step(MINW - 1);
    busrst_n_i = 1'b1;
    push(c4 + MINW, "R9", 6'b000000, M_NOBN);
    push(c4 + MINW + 1, "R9", 6'b000001, M_NOBN);
    push(c4 + MINW + 15, "R9", 6'b000001, M_NOBN);
    step(20);

    // R1: power loss clears the flag; strap high again drives the bus reset
    c5 = cyc;
    pwr_good_i = 1'b0;
    push(c5 + 1, "R1 R2", 6'b111100, M_ALL);
    step(3);

    while (sb_q.size() > 0) step(1);
    finish_run();
  end
endmodule